// File: doc/BRIEF.md
# JTAG Test Access Port with Boundary-Scan Chain

This block is a test access port driven by the four-wire TCK/TMS/TDI/TDO interface. It contains the sixteen-state controller, a four-bit instruction register, a fixed 32-bit identification register, a one-bit bypass register, and a boundary register. The boundary register is a parameterised chain of cells that sits between the pad side and the core side of a set of pins.

Each pin is declared as one of four kinds. The kind sets which cells the pin owns: an input cell, an output cell, an enable cell, or some combination. While the boundary instruction is loaded, the updated cells drive the core inputs, the pad outputs and the pad enables. At all other times every signal passes straight through. A signal that has no cell always passes straight through. The whole port runs on TCK alone and does not depend on the system clock or on the core reset.

Top module: `jtag_bscan_tap`

## Requirements
- R1: After five rising TCK edges with TMS high, the controller is in Test-Logic-Reset, and the instruction register then holds the identification code 4'b0001.
- R2: With the identification instruction selected, a data scan shifts out 32'h000018FF, least significant bit first, and a second scan returns the same value.
- R3: The instruction register is 4 bits wide. Capture-IR loads 4'b0001, so the bits shift out 1,0,0,0. The new code takes effect at Update-IR.
- R4: Code 4'b1111, and every code other than 4'b0000 and 4'b0001, selects a 1-bit bypass register that captures 0. A scan therefore returns the input delayed by one bit, with a leading 0.
- R5: The pin kind is encoded in 2 bits of PIN_KINDS per pin: 0 input, 1 output, 2 tristate output, 3 bidirectional. Cells are ordered pin 0 first, nearest TDO. Within a pin the order is input cell, then output cell, then enable cell, and only the cells the kind needs are present.
- R6: A Capture-DR with code 4'b0000 loads each input cell from pad_in_i, each output cell from core_out_i, and each enable cell from core_oe_i.
- R7: While code 4'b0000 is active, after Update-DR each input cell drives core_in_o, each output cell drives pad_out_o, and each enable cell drives pad_oe_o. Under any other code, and for signals without a cell, core_in_o follows pad_in_i, pad_out_o follows core_out_i, and pad_oe_o follows core_oe_i.
- R8: TDO changes only on the falling edge of TCK. tdo_oe_o is 1 only while the controller is in Shift-IR or Shift-DR.
- R9: Asserting rst_ni low puts the controller into Test-Logic-Reset at once, with the identification code selected and all pins passing through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Active-low asynchronous test reset |
| tms_i | input | 1 | Test mode select |
| tdi_i | input | 1 | Serial test data in |
| tdo_o | output | 1 | Serial test data out, changes on falling TCK |
| tdo_oe_o | output | 1 | TDO drive enable |
| pad_in_i | input | NUM_PINS | Values arriving from the pads |
| core_out_i | input | NUM_PINS | Output values from the core |
| core_oe_i | input | NUM_PINS | Output enables from the core |
| core_in_o | output | NUM_PINS | Input values delivered to the core |
| pad_out_o | output | NUM_PINS | Output values sent to the pads |
| pad_oe_o | output | NUM_PINS | Output enables sent to the pads |

## Verification
The bench uses one pin of each kind and checks where every bit of the chain lands. A design with the cell order swapped inside a pin would return captured values in the wrong positions and would drive the wrong pad from a scanned bit. It reads the identification value twice and loads an undefined code. A design that fails to reload the identification code, or that decodes only 4'b1111 as bypass, would return shifted data with no leading zero. It also checks that a TAP reset, and an asynchronous reset in the middle of a scan, restore pass-through. A design that held the old cell values in place would keep overriding the pads after either reset.

// File: rtl/jtag_bscan_pkg.sv
package jtag_bscan_pkg;
  localparam int IR_W     = 4;
  localparam int MAX_PINS = 64;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI, ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR,
    ST_UPD_DR, ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  localparam logic [IR_W-1:0] IR_BSCAN  = 4'b0000;
  localparam logic [IR_W-1:0] IR_IDCODE = 4'b0001;
  localparam logic [IR_W-1:0] IR_BYPASS = 4'b1111;

  localparam logic [1:0] K_IN = 2'd0, K_OUT = 2'd1, K_TRI = 2'd2, K_BIDIR = 2'd3;

  function automatic int has_in(input logic [1:0] k);
    return (k == K_IN || k == K_BIDIR) ? 1 : 0;
  endfunction

  function automatic int has_out(input logic [1:0] k);
    return (k != K_IN) ? 1 : 0;
  endfunction

  function automatic int has_oe(input logic [1:0] k);
    return (k == K_TRI || k == K_BIDIR) ? 1 : 0;
  endfunction

  function automatic int cell_base(input logic [2*MAX_PINS-1:0] kinds, input int p);
    int acc = 0;
    for (int q = 0; q < p; q++)
      acc += has_in(kinds[2*q+:2]) + has_out(kinds[2*q+:2]) + has_oe(kinds[2*q+:2]);
    return acc;
  endfunction
endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import jtag_bscan_pkg::*;
(
  input  logic       tck_i,
  input  logic       rst_ni,
  input  logic       tms_i,
  output tap_state_e state_o
);
  tap_state_e nxt;

  always_comb begin
    unique case (state_o)
      ST_TLR:    nxt = tms_i ? ST_TLR    : ST_RTI;
      ST_RTI:    nxt = tms_i ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: nxt = tms_i ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = tms_i ? ST_EX1_DR : ST_SHF_DR;
      ST_SHF_DR: nxt = tms_i ? ST_EX1_DR : ST_SHF_DR;
      ST_EX1_DR: nxt = tms_i ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nxt = tms_i ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nxt = tms_i ? ST_UPD_DR : ST_SHF_DR;
      ST_UPD_DR: nxt = tms_i ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: nxt = tms_i ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: nxt = tms_i ? ST_EX1_IR : ST_SHF_IR;
      ST_SHF_IR: nxt = tms_i ? ST_EX1_IR : ST_SHF_IR;
      ST_EX1_IR: nxt = tms_i ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nxt = tms_i ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nxt = tms_i ? ST_UPD_IR : ST_SHF_IR;
      default:   nxt = tms_i ? ST_SEL_DR : ST_RTI;
    endcase
  end

  always_ff @(posedge tck_i or negedge rst_ni)
    if (!rst_ni) state_o <= ST_TLR;
    else         state_o <= nxt;
endmodule

// File: rtl/bsr_chain.sv
module bsr_chain #(
  parameter int LEN = 7
) (
  input  logic           tck_i,
  input  logic           rst_ni,
  input  logic           clear_i,
  input  logic           capture_i,
  input  logic           shift_i,
  input  logic           update_i,
  input  logic           tdi_i,
  input  logic [LEN-1:0] cap_i,
  output logic           so_o,
  output logic [LEN-1:0] upd_o
);
  logic [LEN-1:0] sr_q;

  always_ff @(posedge tck_i or negedge rst_ni)
    if (!rst_ni)        sr_q <= '0;
    else if (capture_i) sr_q <= cap_i;
    else if (shift_i)   sr_q <= {tdi_i, sr_q[LEN-1:1]};

  always_ff @(posedge tck_i or negedge rst_ni)
    if (!rst_ni)       upd_o <= '0;
    else if (clear_i)  upd_o <= '0;
    else if (update_i) upd_o <= sr_q;

  assign so_o = sr_q[0];
endmodule

// File: rtl/pin_mux.sv
module pin_mux
  import jtag_bscan_pkg::*;
#(
  parameter int                     NUM_PINS  = 4,
  parameter logic [2*NUM_PINS-1:0]  PIN_KINDS = '0,
  parameter int                     LEN       = 1
) (
  input  logic                ext_i,
  input  logic [NUM_PINS-1:0] pad_in_i,
  input  logic [NUM_PINS-1:0] core_out_i,
  input  logic [NUM_PINS-1:0] core_oe_i,
  input  logic [LEN-1:0]      upd_i,
  output logic [LEN-1:0]      cap_o,
  output logic [NUM_PINS-1:0] core_in_o,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_oe_o
);
  localparam logic [2*MAX_PINS-1:0] KINDS_X = (2*MAX_PINS)'(PIN_KINDS);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam logic [1:0] K  = PIN_KINDS[2*p+:2];
    localparam int         B  = cell_base(KINDS_X, p);
    localparam int         CO = B + has_in(K);
    localparam int         CE = CO + has_out(K);

    if (has_in(K) != 0) begin : g_in
      assign cap_o[B]     = pad_in_i[p];
      assign core_in_o[p] = ext_i ? upd_i[B] : pad_in_i[p];
    end else begin : g_in_thru
      assign core_in_o[p] = pad_in_i[p];
    end

    if (has_out(K) != 0) begin : g_out
      assign cap_o[CO]    = core_out_i[p];
      assign pad_out_o[p] = ext_i ? upd_i[CO] : core_out_i[p];
    end else begin : g_out_thru
      assign pad_out_o[p] = core_out_i[p];
    end

    if (has_oe(K) != 0) begin : g_oe
      assign cap_o[CE]   = core_oe_i[p];
      assign pad_oe_o[p] = ext_i ? upd_i[CE] : core_oe_i[p];
    end else begin : g_oe_thru
      assign pad_oe_o[p] = core_oe_i[p];
    end
  end
endmodule

// File: rtl/jtag_bscan_tap.sv
module jtag_bscan_tap
  import jtag_bscan_pkg::*;
#(
  parameter int                    NUM_PINS  = 4,
  parameter logic [2*NUM_PINS-1:0] PIN_KINDS = {K_BIDIR, K_TRI, K_OUT, K_IN},
  parameter logic [31:0]           ID_VALUE  = 32'h0000_18FF
) (
  input  logic                tck_i,
  input  logic                rst_ni,
  input  logic                tms_i,
  input  logic                tdi_i,
  output logic                tdo_o,
  output logic                tdo_oe_o,
  input  logic [NUM_PINS-1:0] pad_in_i,
  input  logic [NUM_PINS-1:0] core_out_i,
  input  logic [NUM_PINS-1:0] core_oe_i,
  output logic [NUM_PINS-1:0] core_in_o,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_oe_o
);
  localparam int LEN = cell_base((2*MAX_PINS)'(PIN_KINDS), NUM_PINS);

  tap_state_e       state;
  logic [IR_W-1:0]  ir_sr, ir_q;
  logic [31:0]      id_sr;
  logic             byp_q;
  logic             sel_bsr, sel_id, sel_byp;
  logic             bsr_so, dr_so;
  logic [LEN-1:0]   bsr_cap, bsr_upd;

  tap_fsm u_fsm (.tck_i, .rst_ni, .tms_i, .state_o(state));

  always_comb begin
    sel_bsr = 1'b0;
    sel_id  = 1'b0;
    sel_byp = 1'b0;
    unique case (ir_q)
      IR_BSCAN:  sel_bsr = 1'b1;
      IR_IDCODE: sel_id  = 1'b1;
      IR_BYPASS: sel_byp = 1'b1;
      default:   sel_byp = 1'b1;
    endcase
  end

  always_ff @(posedge tck_i or negedge rst_ni)
    if (!rst_ni)                ir_sr <= IR_IDCODE;
    else if (state == ST_CAP_IR) ir_sr <= IR_W'(2'b01);
    else if (state == ST_SHF_IR) ir_sr <= {tdi_i, ir_sr[IR_W-1:1]};

  always_ff @(posedge tck_i or negedge rst_ni)
    if (!rst_ni)                 ir_q <= IR_IDCODE;
    else if (state == ST_TLR)    ir_q <= IR_IDCODE;
    else if (state == ST_UPD_IR) ir_q <= ir_sr;

  always_ff @(posedge tck_i or negedge rst_ni)
    if (!rst_ni)                           id_sr <= ID_VALUE;
    else if (sel_id && state == ST_CAP_DR) id_sr <= ID_VALUE;
    else if (sel_id && state == ST_SHF_DR) id_sr <= {tdi_i, id_sr[31:1]};

  always_ff @(posedge tck_i or negedge rst_ni)
    if (!rst_ni)                            byp_q <= 1'b0;
    else if (sel_byp && state == ST_CAP_DR) byp_q <= 1'b0;
    else if (sel_byp && state == ST_SHF_DR) byp_q <= tdi_i;

  bsr_chain #(.LEN(LEN)) u_chain (
    .tck_i, .rst_ni,
    .clear_i  (state == ST_TLR),
    .capture_i(sel_bsr && state == ST_CAP_DR),
    .shift_i  (sel_bsr && state == ST_SHF_DR),
    .update_i (sel_bsr && state == ST_UPD_DR),
    .tdi_i,
    .cap_i    (bsr_cap),
    .so_o     (bsr_so),
    .upd_o    (bsr_upd)
  );

  pin_mux #(.NUM_PINS(NUM_PINS), .PIN_KINDS(PIN_KINDS), .LEN(LEN)) u_mux (
    .ext_i(sel_bsr), .pad_in_i, .core_out_i, .core_oe_i,
    .upd_i(bsr_upd), .cap_o(bsr_cap),
    .core_in_o, .pad_out_o, .pad_oe_o
  );

  assign dr_so = sel_bsr ? bsr_so : (sel_id ? id_sr[0] : byp_q);

  // TDO launched on falling edge so the receiver samples on the next rising edge
  always_ff @(negedge tck_i or negedge rst_ni)
    if (!rst_ni) begin
      tdo_o    <= 1'b0;
      tdo_oe_o <= 1'b0;
    end else begin
      tdo_o    <= (state == ST_SHF_IR) ? ir_sr[0] : dr_so;
      tdo_oe_o <= (state == ST_SHF_IR) || (state == ST_SHF_DR);
    end
endmodule

// File: rtl/tap_sva.sv
module tap_sva
  import jtag_bscan_pkg::*;
#(
  parameter int NUM_PINS = 4
) (
  input logic                tck_i,
  input logic                rst_ni,
  input logic                tms_i,
  input logic                tdo_oe_o,
  input tap_state_e          state,
  input logic [IR_W-1:0]     ir_sr,
  input logic [IR_W-1:0]     ir_q,
  input logic [NUM_PINS-1:0] pad_in_i,
  input logic [NUM_PINS-1:0] core_out_i,
  input logic [NUM_PINS-1:0] core_oe_i,
  input logic [NUM_PINS-1:0] core_in_o,
  input logic [NUM_PINS-1:0] pad_out_o,
  input logic [NUM_PINS-1:0] pad_oe_o
);
  logic [2:0] tms_run;

  always_ff @(posedge tck_i or negedge rst_ni)
    if (!rst_ni)    tms_run <= '0;
    else if (!tms_i) tms_run <= '0;
    else if (tms_run != 3'd7) tms_run <= tms_run + 3'd1;

  // R1
  a_r1_tlr_after_five: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (tms_run >= 3'd5) |-> (state == ST_TLR));

  // R1
  a_r1_tlr_loads_id: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state == ST_TLR) |=> (ir_q == IR_IDCODE));

  // R3
  a_r3_ir_capture: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state == ST_CAP_IR) |=> (ir_sr[1:0] == 2'b01));

  // R8
  a_r8_oe_in_shift: assert property (@(posedge tck_i) disable iff (!rst_ni)
    tdo_oe_o == (state == ST_SHF_IR || state == ST_SHF_DR));

  // R7
  a_r7_pass_through: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (ir_q != IR_BSCAN) |->
      (core_in_o == pad_in_i && pad_out_o == core_out_i && pad_oe_o == core_oe_i));
endmodule

bind jtag_bscan_tap tap_sva #(.NUM_PINS(NUM_PINS)) u_sva (
  .tck_i, .rst_ni, .tms_i, .tdo_oe_o,
  .state(state), .ir_sr(ir_sr), .ir_q(ir_q),
  .pad_in_i, .core_out_i, .core_oe_i,
  .core_in_o, .pad_out_o, .pad_oe_o
);

// File: tb/tb_jtag_bscan_tap.sv
module tb_jtag_bscan_tap;
  localparam int N = 4;

  logic tck = 1'b0, rst_ni = 1'b0, tms_i = 1'b1, tdi_i = 1'b0;
  logic tdo_o, tdo_oe_o;
  logic [N-1:0] pad_in_i = '0, core_out_i = '0, core_oe_i = '0;
  logic [N-1:0] core_in_o, pad_out_o, pad_oe_o;

  int checks = 0, failures = 0;
  bit done = 0;

  always #10 tck = ~tck;

  jtag_bscan_tap dut (
    .tck_i(tck), .rst_ni, .tms_i, .tdi_i, .tdo_o, .tdo_oe_o,
    .pad_in_i, .core_out_i, .core_oe_i, .core_in_o, .pad_out_o, .pad_oe_o
  );

  typedef struct { string tag; logic [31:0] v; } item_t;
  item_t exp_q[$], act_q[$];

  task automatic push_exp(input string tag, input logic [31:0] v);
    item_t it; it.tag = tag; it.v = v; exp_q.push_back(it);
  endtask

  task automatic push_act(input logic [31:0] v);
    item_t it; it.tag = ""; it.v = v; act_q.push_back(it);
  endtask

  // monitor: pairs expected with observed items in order
  initial forever begin
    @(posedge tck);
    while (exp_q.size() > 0 && act_q.size() > 0) begin
      item_t e, a;
      e = exp_q.pop_front();
      a = act_q.pop_front();
      checks++;
      if (e.v !== a.v) begin
        failures++;
        $display("FAIL %s actual=%h expected=%h", e.tag, a.v, e.v);
      end
    end
  end

  task automatic step(input logic tms, input logic tdi, output logic so, output logic oe);
    @(negedge tck); #2;
    so = tdo_o; oe = tdo_oe_o;
    tms_i = tms; tdi_i = tdi;
    @(posedge tck); #1;
  endtask

  task automatic tap_reset();
    logic s, o;
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, s, o);
    step(1'b0, 1'b0, s, o);
  endtask

  task automatic shift_dr(input int n, input logic [31:0] din,
                          output logic [31:0] dout, output logic oe_sh);
    logic s, o;
    dout = '0;
    step(1'b1, 1'b0, s, o);
    step(1'b0, 1'b0, s, o);
    step(1'b0, 1'b0, s, o);
    for (int i = 0; i < n; i++) begin
      step(i == n-1, din[i], s, o);
      dout[i] = s;
      if (i == 0) oe_sh = o;
    end
    step(1'b1, 1'b0, s, o);
    step(1'b0, 1'b0, s, o);
  endtask

  task automatic shift_ir(input logic [3:0] code, output logic [3:0] dout);
    logic s, o;
    step(1'b1, 1'b0, s, o);
    step(1'b1, 1'b0, s, o);
    step(1'b0, 1'b0, s, o);
    step(1'b0, 1'b0, s, o);
    for (int i = 0; i < 4; i++) begin
      step(i == 3, code[i], s, o);
      dout[i] = s;
    end
    step(1'b1, 1'b0, s, o);
    step(1'b0, 1'b0, s, o);
  endtask

  task automatic check_pins(input string tag, input logic [N-1:0] ci,
                            input logic [N-1:0] po, input logic [N-1:0] pe);
    push_exp({tag, " core_in"}, 32'(ci));  push_act(32'(core_in_o));
    push_exp({tag, " pad_out"}, 32'(po));  push_act(32'(pad_out_o));
    push_exp({tag, " pad_oe"},  32'(pe));  push_act(32'(pad_oe_o));
  endtask

  initial begin
    #(20 * 50000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [3:0]  irv;
    logic        oe, s, o;

    pad_in_i = 4'b0110; core_out_i = 4'b1010; core_oe_i = 4'b0101;
    #35 rst_ni = 1'b1;
    @(negedge tck); #2;
    // R9 reset state: pass-through, TDO not driven
    check_pins("R9 reset", 4'b0110, 4'b1010, 4'b0101);
    push_exp("R8 oe after reset", 32'd0); push_act(32'(tdo_oe_o));
    step(1'b0, 1'b0, s, o);

    // R2 identification read twice without loading an instruction
    shift_dr(32, 32'hFFFF_FFFF, d, oe);
    push_exp("R2 idcode first", 32'h0000_18FF); push_act(d);
    push_exp("R8 oe in shift-dr", 32'd1); push_act(32'(oe));
    shift_dr(32, 32'h0, d, oe);
    push_exp("R2 idcode second", 32'h0000_18FF); push_act(d);
    @(negedge tck); #2;
    push_exp("R8 oe in idle", 32'd0); push_act(32'(tdo_oe_o));

    // R3 capture pattern, R4 bypass via all-ones
    shift_ir(4'b1111, irv);
    push_exp("R3 ir capture", 32'h1); push_act(32'(irv));
    shift_dr(8, 32'hB2, d, oe);
    push_exp("R4 bypass 1111", 32'h64); push_act(d & 32'hFF);

    // R4 undefined code
    shift_ir(4'b0101, irv);
    shift_dr(8, 32'h5B, d, oe);
    push_exp("R4 bypass undefined", 32'hB6); push_act(d & 32'hFF);

    // R5/R6 capture on the boundary chain; pins: in, out, tri, bidir
    shift_ir(4'b0000, irv);
    pad_in_i = 4'b1001; core_out_i = 4'b0110; core_oe_i = 4'b1000;
    shift_dr(7, 32'b1100101, d, oe);
    push_exp("R6 R5 captured chain", 32'b1010111); push_act(d & 32'h7F);

    // R7 updated cells override; uncelled signals follow inputs
    pad_in_i = '0; core_out_i = '0; core_oe_i = '0;
    @(negedge tck); #2;
    check_pins("R7 R5 scan drive", 4'b0001, 4'b1100, 4'b1000);

    // R1 five TMS-high edges restore identification and pass-through
    tap_reset();
    pad_in_i = 4'b1010; core_out_i = 4'b0101; core_oe_i = 4'b0011;
    @(negedge tck); #2;
    check_pins("R1 tap reset pass", 4'b1010, 4'b0101, 4'b0011);
    shift_dr(32, 32'h0, d, oe);
    push_exp("R1 idcode after tap reset", 32'h0000_18FF); push_act(d);

    // R9 async reset in the middle of a boundary scan
    shift_ir(4'b0000, irv);
    shift_dr(7, 32'h7F, d, oe);
    step(1'b1, 1'b0, s, o);
    step(1'b0, 1'b0, s, o);
    step(1'b0, 1'b0, s, o);
    #3 rst_ni = 1'b0;
    #5 rst_ni = 1'b1;
    @(negedge tck); #2;
    check_pins("R9 async reset pass", 4'b1010, 4'b0101, 4'b0011);
    tms_i = 1'b0;
    @(posedge tck); #1;
    shift_dr(32, 32'h0, d, oe);
    push_exp("R9 idcode after async reset", 32'h0000_18FF); push_act(d);

    repeat (4) @(posedge tck);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule